// File: doc/BRIEF.md
# Test Run Control and Status Unit

This block sits behind a host register port and runs a memory test from start to end. Software writes word-sized values into a small write-only register window. The window holds the status-area base, the source and destination addresses, the line count, a configuration word, an idle threshold, and the interrupt vector and ID. A control word resets, starts or force-completes a run. The request engine, which is outside this block, pulses `req_rd` and `req_wr` for each request it issues, `rsp_seen` for each response and `err_seen` for each error it detects.

While a run is active the unit counts clocks, requests, errors, the lead-in before the first request and the idle tail since the last request. It also watches for long stretches with no traffic. A run ends in one of two ways: the write count reaches the programmed line count, or software sets the force bit. Both endings give the same record. At the end, `stat_valid` pulses for one cycle and the 512-bit `stat_rec` holds the frozen record until the next start or soft reset. Writing the record to memory and sending interrupts are left to other blocks.

Top module: `test_run_ctrl`

## Requirements
- R1: A write with `reg_wr` high stores `reg_wdata` in the register its offset selects. The offsets are 0x1A00 for base[31:0], 0x1A04 for base[63:32], 0x1A20 for source, 0x1A24 for destination, 0x1A28 for line count, 0x1A34 for configuration, 0x1A38 for the idle threshold and 0x1A3C for interrupts (vector in [23:16], ID in [15:0]). The new value shows on the outputs from the cycle after the write. Configuration bit 28 appears on `cfg_intr_on_err` and bit 29 on `cfg_intr_each_run`.
- R2: A write to any other offset has no effect on any output. This includes 0x1A30 and addresses whose upper bits differ from 0x1A.
- R3: Control (0x1A2C) bit 0 is an active-low soft reset and is mirrored on `soft_rst_n`, which is 1 after reset. A control write with bit 0 = 0 clears every configuration register, ends any run and clears the record. While `soft_rst_n` is 0, writes to configuration registers are ignored.
- R4: A control write with bits 0 and 1 both set makes `run_go` high from the next cycle and clears all counters and the completion flag.
- R5: With configuration bit 1 clear, a run completes at the clock edge where a write request makes the write count equal a non-zero line count. A line count of 0 never completes a run.
- R6: A control write with bit 0 set, bit 2 set and bit 1 clear during a run completes it exactly like R5. The same write outside a run has no effect.
- R7: On completion `run_go` falls and `stat_valid` is high for exactly one cycle.
- R8: Each record field is counted over the edges on which `run_go` is high. The fields are: [31:0] completion flag (1 when complete); [63:32] error count; [127:64] clock count; [159:128] read-request count; [191:160] write-request count; [223:192] idle cycles before the first request; [255:224] idle cycles since the last request; [319:256] clock count at the first error; [511:320] zero.
- R9: After completion the record stays unchanged until the next start or soft reset, whatever the traffic inputs do.
- R10: The idle counter advances only on run cycles with no request and no response, returns to 0 on any of them, and saturates at its maximum.
- R11: `idle_timeout` is high exactly while the idle count is strictly greater than the threshold register.
- R12: With configuration bit 1 set (continuous mode), reaching the line count does not end the run; only R6 or R3 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| req_rd | input | 1 | Read request issued this cycle |
| req_wr | input | 1 | Write request issued this cycle |
| rsp_seen | input | 1 | Response received this cycle |
| err_seen | input | 1 | Error detected this cycle |
| run_go | output | 1 | Run active level |
| soft_rst_n | output | 1 | Soft reset, active low |
| status_base | output | 64 | Status-area base address |
| src_addr | output | 32 | Source buffer address |
| dst_addr | output | 32 | Destination buffer address |
| line_cnt | output | 32 | Lines per run |
| cfg_word | output | 32 | Configuration word |
| cfg_intr_on_err | output | 1 | Interrupt-on-error request bit |
| cfg_intr_each_run | output | 1 | Interrupt-every-run test bit |
| intr_vector | output | 8 | Stored interrupt vector |
| intr_id | output | 16 | Stored interrupt ID |
| idle_timeout | output | 1 | Idle count above threshold |
| stat_valid | output | 1 | One-cycle completion pulse |
| stat_rec | output | 512 | Status record |

## Verification
Every register write and traffic pulse is sampled on one rising edge, and its effect is due right after that same edge. Stored registers, `soft_rst_n`, `run_go`, the counters, `stat_valid` and `idle_timeout` all change there. None of these paths has a second pipeline stage. The bench drives inputs on the falling edge and samples all outputs on the next falling edge. It keeps a cycle-by-cycle model of the counters that advances only on edges where its own run flag is set. The completion pulse is checked after every driven cycle, so a pulse that comes early, comes late or lasts two cycles is caught.

// File: rtl/trc_pkg.sv
// Shared offsets, bit positions and the status record layout for the
// test run control unit. Assumes a 16-bit byte offset and 32-bit words.
package trc_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned CLK_W  = 64;
    localparam int unsigned OFF_W  = 16;
    localparam int unsigned REC_W  = 512;

    localparam logic [OFF_W-1:0] OFF_BASE_LO = 16'h1A00;
    localparam logic [OFF_W-1:0] OFF_BASE_HI = 16'h1A04;
    localparam logic [OFF_W-1:0] OFF_SRC     = 16'h1A20;
    localparam logic [OFF_W-1:0] OFF_DST     = 16'h1A24;
    localparam logic [OFF_W-1:0] OFF_LINES   = 16'h1A28;
    localparam logic [OFF_W-1:0] OFF_CTRL    = 16'h1A2C;
    localparam logic [OFF_W-1:0] OFF_CFG     = 16'h1A34;
    localparam logic [OFF_W-1:0] OFF_IDLE    = 16'h1A38;
    localparam logic [OFF_W-1:0] OFF_INTR    = 16'h1A3C;

    localparam int unsigned CTL_NRST  = 0;
    localparam int unsigned CTL_GO    = 1;
    localparam int unsigned CTL_FORCE = 2;
    localparam int unsigned CFG_CONT  = 1;
    localparam int unsigned CFG_IERR  = 28;
    localparam int unsigned CFG_ITEST = 29;

    typedef struct packed {
        logic [REC_W-6*WORD_W-2*CLK_W-1:0] pad;
        logic [CLK_W-1:0]  first_err;
        logic [WORD_W-1:0] tail_idle;
        logic [WORD_W-1:0] lead_idle;
        logic [WORD_W-1:0] wr_n;
        logic [WORD_W-1:0] rd_n;
        logic [CLK_W-1:0]  clocks;
        logic [WORD_W-1:0] err_n;
        logic [WORD_W-1:0] done_flag;
    } rec_t;
endpackage

// File: rtl/trc_regs.sv
// Write-only register window. Decodes word writes and holds the setup
// registers and the soft reset bit. The go and force decodes are
// combinational so the run logic acts on the same edge as the write.
// Assumes at most one write per cycle.
module trc_regs
    import trc_pkg::*;
#(
    parameter int unsigned AW = OFF_W,
    parameter int unsigned DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          soft_rst_n,
    output logic          clr_all,
    output logic          go_req,
    output logic          force_req,
    output logic [2*DW-1:0] base,
    output logic [DW-1:0] src,
    output logic [DW-1:0] dst,
    output logic [DW-1:0] lines,
    output logic [DW-1:0] cfg,
    output logic [DW-1:0] idle_lim,
    output logic [DW-1:0] intr
);
    logic ctl_hit;

    // decode of the control word for this cycle
    assign ctl_hit   = wr_en && (wr_addr == OFF_CTRL);
    assign go_req    = ctl_hit && wr_data[CTL_NRST] && wr_data[CTL_GO];
    assign force_req = ctl_hit && wr_data[CTL_NRST] && wr_data[CTL_FORCE]
                       && !wr_data[CTL_GO];
    assign clr_all   = ctl_hit ? !wr_data[CTL_NRST] : !soft_rst_n;

    // soft reset bit follows every control write
    always_ff @(posedge clk) begin
        if (!rst_n)       soft_rst_n <= 1'b1;
        else if (ctl_hit) soft_rst_n <= wr_data[CTL_NRST];
    end

    // setup registers: cleared under soft reset, else written by offset
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            base     <= '0;
            src      <= '0;
            dst      <= '0;
            lines    <= '0;
            cfg      <= '0;
            idle_lim <= '0;
            intr     <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                OFF_BASE_LO: base[DW-1:0]    <= wr_data;
                OFF_BASE_HI: base[2*DW-1:DW] <= wr_data;
                OFF_SRC:     src      <= wr_data;
                OFF_DST:     dst      <= wr_data;
                OFF_LINES:   lines    <= wr_data;
                OFF_CFG:     cfg      <= wr_data;
                OFF_IDLE:    idle_lim <= wr_data;
                OFF_INTR:    intr     <= wr_data;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/trc_evcnt.sv
// Counter of single-cycle events, cleared on demand and advanced only
// while enabled. Wraps at its width; that width is assumed wide enough.
module trc_evcnt #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         ev,
    output logic [W-1:0] cnt
);
    // count qualified events
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (en && ev)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/trc_stats.sv
// Run statistics: clock count, request and error counts, lead-in and tail
// idle spans, first-error time and a saturating idle-traffic counter.
// Everything advances only while 'active'; 'clr' wins over counting.
module trc_stats #(
    parameter int unsigned CW = 32,
    parameter int unsigned KW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          active,
    input  logic          req_rd,
    input  logic          req_wr,
    input  logic          rsp,
    input  logic          err,
    output logic [KW-1:0] clocks,
    output logic [CW-1:0] rd_n,
    output logic [CW-1:0] wr_n,
    output logic [CW-1:0] err_n,
    output logic [CW-1:0] lead_idle,
    output logic [CW-1:0] tail_idle,
    output logic [CW-1:0] idle_n,
    output logic [KW-1:0] first_err
);
    localparam int unsigned NEV = 3;

    logic [NEV-1:0]         ev_vec;
    logic [NEV-1:0][CW-1:0] ev_cnt;
    logic                   any_req;
    logic                   seen_req;
    logic                   seen_err;

    assign ev_vec  = {err, req_wr, req_rd};
    assign any_req = req_rd || req_wr;

    for (genvar k = 0; k < NEV; k++) begin : g_ev
        trc_evcnt #(.W(CW)) cnt_i (
            .clk(clk), .rst_n(rst_n), .clr(clr), .en(active),
            .ev(ev_vec[k]), .cnt(ev_cnt[k])
        );
    end

    assign rd_n  = ev_cnt[0];
    assign wr_n  = ev_cnt[1];
    assign err_n = ev_cnt[2];

    // clock count and first-error time stamp
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            clocks    <= '0;
            first_err <= '0;
            seen_err  <= 1'b0;
        end else if (active) begin
            clocks <= clocks + 1'b1;
            if (err && !seen_err) begin
                first_err <= clocks;
                seen_err  <= 1'b1;
            end
        end
    end

    // lead-in before the first request and tail since the last one
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lead_idle <= '0;
            tail_idle <= '0;
            seen_req  <= 1'b0;
        end else if (active) begin
            if (any_req) seen_req <= 1'b1;
            else if (!seen_req) lead_idle <= lead_idle + 1'b1;
            tail_idle <= any_req ? '0 : tail_idle + 1'b1;
        end
    end

    // saturating count of consecutive cycles with no traffic
    always_ff @(posedge clk) begin
        if (!rst_n || clr)           idle_n <= '0;
        else if (active) begin
            if (any_req || rsp)      idle_n <= '0;
            else if (idle_n != '1)   idle_n <= idle_n + 1'b1;
        end
    end
endmodule

// File: rtl/trc_run.sv
// Run state: starts on a go write, ends on the line-count match (unless
// continuous) or on a force write, and emits a one-cycle completion pulse.
// Assumes wr_count is the write count before the current edge.
module trc_run #(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          go,
    input  logic          force_req,
    input  logic          wr_pulse,
    input  logic          cont,
    input  logic [CW-1:0] lines,
    input  logic [CW-1:0] wr_count,
    output logic          active,
    output logic          done,
    output logic          fin_pulse
);
    logic hit_lines;
    logic finish;

    assign hit_lines = wr_pulse && !cont && (lines != '0)
                       && (CW'(wr_count + 1'b1) == lines);
    assign finish    = active && !clr && !go && (force_req || hit_lines);

    // run, done and completion pulse state
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            active    <= 1'b0;
            done      <= 1'b0;
            fin_pulse <= 1'b0;
        end else begin
            fin_pulse <= finish;
            if (go) begin
                active <= 1'b1;
                done   <= 1'b0;
            end else if (finish) begin
                active <= 1'b0;
                done   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/test_run_ctrl.sv
// Top of the test run control unit: register window, run state and
// statistics, assembled into the 512-bit status record.
module test_run_ctrl
    import trc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [OFF_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic              rsp_seen,
    input  logic              err_seen,
    output logic              run_go,
    output logic              soft_rst_n,
    output logic [2*WORD_W-1:0] status_base,
    output logic [WORD_W-1:0] src_addr,
    output logic [WORD_W-1:0] dst_addr,
    output logic [WORD_W-1:0] line_cnt,
    output logic [WORD_W-1:0] cfg_word,
    output logic              cfg_intr_on_err,
    output logic              cfg_intr_each_run,
    output logic [7:0]        intr_vector,
    output logic [15:0]       intr_id,
    output logic              idle_timeout,
    output logic              stat_valid,
    output logic [REC_W-1:0]  stat_rec
);
    logic              clr_all, go_req, force_req, done;
    logic [WORD_W-1:0] idle_lim, intr_word;
    logic [WORD_W-1:0] rd_n, wr_n, err_n, lead_idle, tail_idle, idle_n;
    logic [CLK_W-1:0]  clocks, first_err;
    rec_t              rec;

    trc_regs #(.AW(OFF_W), .DW(WORD_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .soft_rst_n(soft_rst_n), .clr_all(clr_all),
        .go_req(go_req), .force_req(force_req), .base(status_base),
        .src(src_addr), .dst(dst_addr), .lines(line_cnt), .cfg(cfg_word),
        .idle_lim(idle_lim), .intr(intr_word)
    );

    trc_run #(.CW(WORD_W)) run_i (
        .clk(clk), .rst_n(rst_n), .clr(clr_all), .go(go_req),
        .force_req(force_req), .wr_pulse(req_wr), .cont(cfg_word[CFG_CONT]),
        .lines(line_cnt), .wr_count(wr_n), .active(run_go), .done(done),
        .fin_pulse(stat_valid)
    );

    trc_stats #(.CW(WORD_W), .KW(CLK_W)) stats_i (
        .clk(clk), .rst_n(rst_n), .clr(clr_all || go_req), .active(run_go),
        .req_rd(req_rd), .req_wr(req_wr), .rsp(rsp_seen), .err(err_seen),
        .clocks(clocks), .rd_n(rd_n), .wr_n(wr_n), .err_n(err_n),
        .lead_idle(lead_idle), .tail_idle(tail_idle), .idle_n(idle_n),
        .first_err(first_err)
    );

    assign cfg_intr_on_err   = cfg_word[CFG_IERR];
    assign cfg_intr_each_run = cfg_word[CFG_ITEST];
    assign intr_vector       = intr_word[23:16];
    assign intr_id           = intr_word[15:0];
    assign idle_timeout      = idle_n > idle_lim;

    // record assembly in field order
    always_comb begin
        rec           = '0;
        rec.done_flag = WORD_W'(done);
        rec.err_n     = err_n;
        rec.clocks    = clocks;
        rec.rd_n      = rd_n;
        rec.wr_n      = wr_n;
        rec.lead_idle = lead_idle;
        rec.tail_idle = tail_idle;
        rec.first_err = first_err;
    end
    assign stat_rec = rec;
endmodule

// File: rtl/trc_chk.sv
// Protocol checks for test_run_ctrl, attached through bind.
module trc_chk
    import trc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [OFF_W-1:0] reg_addr,
    input logic             run_go,
    input logic             soft_rst_n,
    input logic [WORD_W-1:0] cfg_word,
    input logic             idle_timeout,
    input logic             stat_valid,
    input logic [REC_W-1:0] stat_rec
);
    // R7
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid);
    // R7
    end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> !run_go);
    // R4
    go_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_go) |-> $past(reg_wr && (reg_addr == OFF_CTRL)));
    // R3
    soft_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst_n |-> (cfg_word == '0));
    // R11
    idle_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_timeout) |-> ($past(run_go) || $past(reg_wr)));
    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_go && !reg_wr) |=> $stable(stat_rec));
endmodule

bind test_run_ctrl trc_chk chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .run_go(run_go), .soft_rst_n(soft_rst_n), .cfg_word(cfg_word),
    .idle_timeout(idle_timeout), .stat_valid(stat_valid), .stat_rec(stat_rec)
);

// File: tb/test_run_ctrl_tb_top.sv
`timescale 1ns/1ps
module test_run_ctrl_tb_top;
    localparam logic [15:0] A_BLO = 16'h1A00, A_BHI = 16'h1A04, A_SRC = 16'h1A20,
                            A_DST = 16'h1A24, A_LIN = 16'h1A28, A_CTL = 16'h1A2C,
                            A_CFG = 16'h1A34, A_IDL = 16'h1A38, A_INT = 16'h1A3C;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic req_rd = 1'b0, req_wr = 1'b0, rsp_seen = 1'b0, err_seen = 1'b0;
    logic run_go, soft_rst_n, cfg_intr_on_err, cfg_intr_each_run;
    logic idle_timeout, stat_valid;
    logic [63:0] status_base;
    logic [31:0] src_addr, dst_addr, line_cnt, cfg_word;
    logic [7:0] intr_vector;
    logic [15:0] intr_id;
    logic [511:0] stat_rec;

    int n_tests = 0, n_fail = 0;

    // bench model of the run
    logic [63:0] e_clk, e_first;
    logic [31:0] e_rd, e_wr, e_err, e_soh, e_eoh, e_idle;
    logic [31:0] e_lines = '0, e_thresh = '0;
    logic e_cont = 1'b0, e_active = 1'b0, e_done = 1'b0;
    logic e_seen_req, e_seen_err;

    always #5 clk = ~clk;

    test_run_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .req_rd(req_rd), .req_wr(req_wr),
        .rsp_seen(rsp_seen), .err_seen(err_seen), .run_go(run_go),
        .soft_rst_n(soft_rst_n), .status_base(status_base), .src_addr(src_addr),
        .dst_addr(dst_addr), .line_cnt(line_cnt), .cfg_word(cfg_word),
        .cfg_intr_on_err(cfg_intr_on_err), .cfg_intr_each_run(cfg_intr_each_run),
        .intr_vector(intr_vector), .intr_id(intr_id), .idle_timeout(idle_timeout),
        .stat_valid(stat_valid), .stat_rec(stat_rec)
    );

    task automatic check(input string req, input string what,
                         input logic [511:0] act, input logic [511:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wreg(input logic [15:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    endtask

    function automatic void mdl_zero();
        e_clk = '0; e_first = '0; e_rd = '0; e_wr = '0; e_err = '0;
        e_soh = '0; e_eoh = '0; e_idle = '0; e_seen_req = 1'b0;
        e_seen_err = 1'b0; e_done = 1'b0;
    endfunction

    // advance the model by one run cycle; returns a normal-completion flag
    function automatic logic mdl_cycle(input logic rd, wr, rsp, er);
        logic hit = 1'b0;
        if (e_active) begin
            if (er && !e_seen_err) begin e_first = e_clk; e_seen_err = 1'b1; end
            e_clk = e_clk + 64'd1;
            e_rd  = e_rd + 32'(rd);
            e_wr  = e_wr + 32'(wr);
            e_err = e_err + 32'(er);
            if (!e_seen_req && !(rd || wr)) e_soh = e_soh + 32'd1;
            if (rd || wr) begin e_seen_req = 1'b1; e_eoh = '0; end
            else e_eoh = e_eoh + 32'd1;
            if (rd || wr || rsp) e_idle = '0;
            else if (e_idle != '1) e_idle = e_idle + 32'd1;
            hit = wr && !e_cont && (e_lines != 0) && (e_wr == e_lines);
        end
        return hit;
    endfunction

    task automatic step(input logic rd, wr, rsp, er);
        logic fin;
        fin = mdl_cycle(rd, wr, rsp, er);
        req_rd = rd; req_wr = wr; rsp_seen = rsp; err_seen = er;
        @(negedge clk);
        req_rd = 1'b0; req_wr = 1'b0; rsp_seen = 1'b0; err_seen = 1'b0;
        if (fin) begin e_active = 1'b0; e_done = 1'b1; end
        check("R7", "stat_valid", 512'(stat_valid), 512'(fin));
    endtask

    task automatic start_run();
        wreg(A_CTL, 32'h3);
        mdl_zero();
        e_active = 1'b1;
        check("R4", "run_go after start", 512'(run_go), 512'(1));
        check("R4", "clock count cleared", 512'(stat_rec[127:64]), 512'(0));
    endtask

    task automatic soft_reset();
        wreg(A_CTL, 32'h0);
        wreg(A_CTL, 32'h1);
        mdl_zero();
        e_active = 1'b0; e_lines = '0; e_cont = 1'b0; e_thresh = '0;
    endtask

    task automatic check_rec(input string req);
        check(req, "done flag", 512'(stat_rec[31:0]), 512'({31'd0, e_done}));
        check("R8", "errors", 512'(stat_rec[63:32]), 512'(e_err));
        check("R8", "clocks", 512'(stat_rec[127:64]), 512'(e_clk));
        check("R8", "reads", 512'(stat_rec[159:128]), 512'(e_rd));
        check("R8", "writes", 512'(stat_rec[191:160]), 512'(e_wr));
        check("R8", "lead idle", 512'(stat_rec[223:192]), 512'(e_soh));
        check("R8", "tail idle", 512'(stat_rec[255:224]), 512'(e_eoh));
        check("R8", "first error", 512'(stat_rec[319:256]), 512'(e_first));
        check("R8", "pad", 512'(stat_rec[511:320]), 512'(0));
    endtask

    task automatic t_reset();
        check("R3", "soft_rst_n at reset", 512'(soft_rst_n), 512'(1));
        check("R4", "run_go at reset", 512'(run_go), 512'(0));
        check("R7", "stat_valid at reset", 512'(stat_valid), 512'(0));
        check("R11", "timeout at reset", 512'(idle_timeout), 512'(0));
        check("R1", "cfg at reset", 512'(cfg_word), 512'(0));
        check("R8", "record at reset", stat_rec, 512'(0));
    endtask

    task automatic t_regs();
        logic [511:0] snap;
        wreg(A_BLO, 32'h1111_2222); wreg(A_BHI, 32'h3333_4444);
        wreg(A_SRC, 32'h0010_0000); wreg(A_DST, 32'h0020_0000);
        wreg(A_LIN, 32'd7);         wreg(A_CFG, 32'h3000_0001);
        wreg(A_INT, 32'h00AB_1234); wreg(A_IDL, 32'd9);
        check("R1", "base", 512'(status_base), 512'(64'h3333_4444_1111_2222));
        check("R1", "src", 512'(src_addr), 512'(32'h0010_0000));
        check("R1", "dst", 512'(dst_addr), 512'(32'h0020_0000));
        check("R1", "lines", 512'(line_cnt), 512'(7));
        check("R1", "cfg", 512'(cfg_word), 512'(32'h3000_0001));
        check("R1", "intr on err bit", 512'(cfg_intr_on_err), 512'(1));
        check("R1", "intr each run bit", 512'(cfg_intr_each_run), 512'(1));
        check("R1", "vector", 512'(intr_vector), 512'(8'hAB));
        check("R1", "id", 512'(intr_id), 512'(16'h1234));
        snap = {status_base, src_addr, dst_addr, line_cnt, cfg_word, intr_vector,
                intr_id, run_go, soft_rst_n};
        wreg(16'h1A30, 32'hFFFF_FFFF);
        wreg(16'h0A2C, 32'h0000_0000);
        wreg(16'h0A2C, 32'h0000_0003);
        wreg(16'h1A21, 32'h0);
        check("R2", "outputs after unmapped writes",
              512'({status_base, src_addr, dst_addr, line_cnt, cfg_word, intr_vector,
                    intr_id, run_go, soft_rst_n}), snap);
    endtask

    task automatic t_soft();
        wreg(A_CTL, 32'h0);
        check("R3", "soft_rst_n low", 512'(soft_rst_n), 512'(0));
        check("R3", "setup cleared",
              512'({status_base, src_addr, dst_addr, line_cnt, cfg_word, intr_vector,
                    intr_id}), 512'(0));
        wreg(A_SRC, 32'h55);
        check("R3", "write ignored in soft reset", 512'(src_addr), 512'(0));
        wreg(A_CTL, 32'h1);
        check("R3", "soft_rst_n released", 512'(soft_rst_n), 512'(1));
    endtask

    task automatic t_normal();
        logic [511:0] snap;
        wreg(A_LIN, 32'd3); e_lines = 32'd3;
        wreg(A_IDL, 32'hFFFF_FFFF); e_thresh = 32'hFFFF_FFFF;
        start_run();
        step(0,0,0,0); step(0,0,0,0); step(1,0,0,0); step(0,0,1,0);
        step(1,1,0,0); step(0,0,0,1); step(0,0,0,0); step(0,1,0,0);
        step(0,0,0,1); step(0,1,0,0);
        check("R5", "run ends at line count", 512'(run_go), 512'(0));
        check_rec("R5");
        snap = stat_rec;
        step(1,1,1,1); step(0,1,0,0);
        check("R9", "record frozen", stat_rec, snap);
        start_run();
        check("R4", "done flag cleared on start", 512'(stat_rec[31:0]), 512'(0));
    endtask

    task automatic t_force();
        logic [511:0] snap;
        logic fin;
        soft_reset();
        start_run();
        step(1,0,0,0); step(0,1,0,0); step(0,1,0,0); step(0,0,0,0);
        check("R5", "zero line count keeps running", 512'(run_go), 512'(1));
        fin = mdl_cycle(0,0,0,0);
        wreg(A_CTL, 32'h5);
        e_active = 1'b0; e_done = 1'b1;
        check("R6", "forced pulse", 512'(stat_valid), 512'(1));
        check("R6", "forced stop", 512'(run_go), 512'(0));
        check_rec("R6");
        snap = stat_rec;
        wreg(A_CTL, 32'h5);
        check("R6", "force outside run no pulse", 512'(stat_valid), 512'(0));
        check("R6", "force outside run record", stat_rec, snap);
        check("R6", "no normal end during force", 512'(fin), 512'(0));
    endtask

    task automatic t_idle();
        soft_reset();
        wreg(A_IDL, 32'd2); e_thresh = 32'd2;
        step(0,0,0,0); step(0,0,0,0); step(0,0,0,0); step(0,0,0,0);
        check("R10", "no idle count outside run", 512'(idle_timeout), 512'(0));
        start_run();
        step(0,0,0,0); step(0,0,0,0);
        check("R11", "count equal to limit", 512'(idle_timeout), 512'(e_idle > e_thresh));
        step(0,0,0,0);
        check("R11", "count above limit", 512'(idle_timeout), 512'(1));
        step(0,0,1,0);
        check("R10", "response clears count", 512'(idle_timeout), 512'(0));
        step(0,0,0,0); step(0,0,0,0);
        check("R10", "recount to limit", 512'(idle_timeout), 512'(0));
        step(0,0,0,0);
        check("R11", "above limit again", 512'(idle_timeout), 512'(1));
        step(1,0,0,0);
        check("R10", "request clears count", 512'(idle_timeout), 512'(0));
    endtask

    task automatic t_cont();
        soft_reset();
        wreg(A_LIN, 32'd2); e_lines = 32'd2;
        wreg(A_CFG, 32'h2); e_cont = 1'b1;
        start_run();
        step(0,1,0,0); step(0,1,0,0); step(0,1,0,0);
        check("R12", "continuous run stays active", 512'(run_go), 512'(1));
        check("R12", "writes counted past limit", 512'(stat_rec[191:160]), 512'(3));
        wreg(A_CTL, 32'h0);
        check("R12", "soft reset ends continuous run", 512'(run_go), 512'(0));
        check("R3", "record cleared by soft reset", stat_rec, 512'(0));
        wreg(A_CTL, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_soft();
        t_normal();
        t_force();
        t_idle();
        t_cont();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule